// File: doc/BRIEF.md
# Operand Address Generator

This block turns an addressing-mode code into the 16-bit effective address of an instruction's operand, for an 8-bit processor core with a 16-bit address space. The caller pulses `start` with the mode code, the program counter (already pointing at the first byte after the opcode) and the two index registers. The block latches these values. It then reads the operand byte or bytes, and any pointer bytes, one byte per cycle through a read port to a synchronous memory. When done it raises `addrValid` for a single cycle. In that cycle it shows the address and the number of operand bytes it consumed, so the caller can advance its program counter.

The block supports immediate, zero-page, zero-page indexed by either register, absolute, absolute indexed by either register, pre-indexed indirect and post-indexed indirect addressing. Index arithmetic that selects a zero-page location wraps within the page. This includes the fetch of the second pointer byte. Arithmetic on full addresses wraps at 65536. A code that names no addressing mode raises `modeErr` for one cycle instead of `addrValid`.

Memory timing: a read issued with `memRd` high in one cycle returns its byte on `memData` during the following cycle.

Top module: `oag_top`

## Requirements
- R1: `start` is taken only while `busy` is low. `busy` then rises in the next cycle, and the latched mode, PC, X and Y are used until the end strobe. `start` and any changes of the other inputs while `busy` is high have no effect on the reads or the result.
- R2: Mode code 0 (immediate) raises `addrValid` one cycle after `start`, with `effAddr` equal to the PC and `opLen` = 1. It issues no memory read.
- R3: Mode code 1 (zero page) reads the byte at the PC in the first cycle after `start`. It gives `effAddr` = {8'h00, byte} with `opLen` = 1, and `addrValid` comes three cycles after `start`.
- R4: Mode codes 2 and 3 (zero page indexed by X, by Y) behave as R3, except that `effAddr` = {8'h00, (byte + index) mod 256}.
- R5: Mode code 4 (absolute) reads the PC in cycle 1 and (PC + 1) mod 65536 in cycle 2. The first byte is the low byte. `effAddr` = {high, low}, `opLen` = 2, and `addrValid` comes four cycles after `start`.
- R6: Mode codes 5 and 6 (absolute indexed by X, by Y) behave as R5, except that `effAddr` = ({high, low} + zero-extended index) mod 65536.
- R7: Mode code 7 (pre-indexed indirect) reads the operand at the PC in cycle 1 and forms P = (operand + X) mod 256. It reads the low byte at P in cycle 3 and the high byte at (P + 1) mod 256 in cycle 4. `effAddr` = {high, low}, `opLen` = 1, and `addrValid` comes six cycles after `start`.
- R8: Mode code 8 (post-indexed indirect) reads the operand at the PC in cycle 1. It reads the low byte at the operand in cycle 3 and the high byte at (operand + 1) mod 256 in cycle 4. `effAddr` = ({high, low} + Y) mod 65536, `opLen` = 1, and `addrValid` comes six cycles after `start`.
- R9: Mode codes 9 to 15 raise `modeErr` for one cycle, one cycle after `start`, with `opLen` = 0. They raise no `addrValid` and issue no memory read.
- R10: `addrValid` and `modeErr` are never high together, and each lasts a single cycle. `busy` is low in the cycle after either strobe. `memRd` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken while idle |
| modeIn | input | 4 | Addressing-mode code |
| pcIn | input | 16 | Program counter, pointing at the first operand byte |
| xIn | input | 8 | X index value |
| yIn | input | 8 | Y index value |
| memRd | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memData | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | A request is in progress |
| addrValid | output | 1 | One-cycle strobe: effective address ready |
| modeErr | output | 1 | One-cycle strobe: unsupported mode code |
| effAddr | output | 16 | Effective address, meaningful with `addrValid` |
| opLen | output | 2 | Operand bytes consumed, meaningful with either strobe |

## Verification
Each result has a fixed latency after the cycle in which `start` is taken:
- one cycle for immediate and for rejected codes,
- three cycles for zero-page forms,
- four cycles for absolute forms,
- six cycles for both indirect forms.

The read requests are due in cycles 1 and 2 for absolute forms, and in cycles 1, 3 and 4 for indirect forms. The bench model builds, for each request, a table of the expected strobe, busy and read-request state indexed by cycle number. It compares the ports against that table at every falling edge, so an early, late or extra event is reported in the cycle where it occurs. Several runs also hold `start` high with different inputs during the busy window, to show that the cycle table and the result do not change.

// File: rtl/oag_pkg.sv
package oag_pkg;

  // Addressing-mode codes seen on modeIn
  localparam logic [3:0] MODE_IMM  = 4'd0;
  localparam logic [3:0] MODE_ZP   = 4'd1;
  localparam logic [3:0] MODE_ZPX  = 4'd2;
  localparam logic [3:0] MODE_ZPY  = 4'd3;
  localparam logic [3:0] MODE_ABS  = 4'd4;
  localparam logic [3:0] MODE_ABSX = 4'd5;
  localparam logic [3:0] MODE_ABSY = 4'd6;
  localparam logic [3:0] MODE_INDX = 4'd7;
  localparam logic [3:0] MODE_INDY = 4'd8;
  localparam logic [3:0] MODE_NONE = 4'd9;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_OP0,
    ST_RD_OP1,
    ST_CAP_OP,
    ST_RD_PLO,
    ST_RD_PHI,
    ST_CAP_HI,
    ST_DONE,
    ST_FAULT
  } seqState_e;

  // Which address the read port presents
  typedef enum logic [1:0] {
    SRC_PC,
    SRC_PC1,
    SRC_PTR,
    SRC_PTR1
  } rdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   latch;
    logic   rdEn;
    rdSrc_e rdSrc;
    logic   capOp;
    logic   capLo;
    logic   capHi;
  } ctrlStrobe_t;

  function automatic logic isAbsMode(input logic [3:0] m);
    return (m == MODE_ABS) || (m == MODE_ABSX) || (m == MODE_ABSY);
  endfunction

  function automatic logic isIndMode(input logic [3:0] m);
    return (m == MODE_INDX) || (m == MODE_INDY);
  endfunction

endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  modeIn,
  output logic [3:0]  modeQ,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        addrValid,
  output logic        modeErr
);

  seqState_e state, stateNext;
  logic      takeReq;
  logic      badMode;

  assign takeReq = start && (state == ST_IDLE);
  assign badMode = (modeIn > MODE_INDY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= MODE_IMM;
    end else begin
      state <= stateNext;
      if (takeReq) modeQ <= badMode ? MODE_NONE : modeIn;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (badMode)                 stateNext = ST_FAULT;
          else if (modeIn == MODE_IMM) stateNext = ST_DONE;
          else                         stateNext = ST_RD_OP0;
        end
      end
      ST_RD_OP0: stateNext = isAbsMode(modeQ) ? ST_RD_OP1 : ST_CAP_OP;
      ST_RD_OP1: stateNext = ST_CAP_HI;
      ST_CAP_OP: stateNext = isIndMode(modeQ) ? ST_RD_PLO : ST_DONE;
      ST_RD_PLO: stateNext = ST_RD_PHI;
      ST_RD_PHI: stateNext = ST_CAP_HI;
      ST_CAP_HI: stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      ST_FAULT:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe       = '0;
    strobe.rdSrc = SRC_PC;
    strobe.latch = takeReq;
    unique case (state)
      ST_RD_OP0: begin
        strobe.rdEn  = 1'b1;
        strobe.rdSrc = SRC_PC;
      end
      ST_RD_OP1: begin
        strobe.rdEn  = 1'b1;
        strobe.rdSrc = SRC_PC1;
        strobe.capLo = 1'b1;
      end
      ST_CAP_OP: strobe.capOp = 1'b1;
      ST_RD_PLO: begin
        strobe.rdEn  = 1'b1;
        strobe.rdSrc = SRC_PTR;
      end
      ST_RD_PHI: begin
        strobe.rdEn  = 1'b1;
        strobe.rdSrc = SRC_PTR1;
        strobe.capLo = 1'b1;
      end
      ST_CAP_HI: strobe.capHi = 1'b1;
      default: ;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign addrValid = (state == ST_DONE);
  assign modeErr   = (state == ST_FAULT);

endmodule

// File: rtl/oag_dpath.sv
module oag_dpath
  import oag_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        modeQ,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] xIn,
  input  logic [BYTE_W-1:0] yIn,
  input  logic [BYTE_W-1:0] memData,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LEN_W-1:0]  opLen
);

  localparam logic [BYTE_W-1:0] ZERO_BYTE = '0;
  localparam logic [BYTE_W-1:0] ONE_BYTE  = BYTE_W'(1);
  localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

  logic [ADDR_W-1:0] pcQ;
  logic [BYTE_W-1:0] xQ, yQ, opQ, loQ, hiQ;
  logic [BYTE_W-1:0] ptrLo, ptrHi, zpSum, idx;
  logic [ADDR_W-1:0] fullBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      xQ  <= '0;
      yQ  <= '0;
      opQ <= '0;
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (strobe.latch) begin
        pcQ <= pcIn;
        xQ  <= xIn;
        yQ  <= yIn;
      end
      if (strobe.capOp) opQ <= memData;
      if (strobe.capLo) loQ <= memData;
      if (strobe.capHi) hiQ <= memData;
    end
  end

  // Page-zero pointer: pre-indexed adds X, post-indexed uses the operand as is
  assign ptrLo = (modeQ == MODE_INDX) ? BYTE_W'(opQ + xQ) : opQ;
  assign ptrHi = BYTE_W'(ptrLo + ONE_BYTE);

  assign memRd = strobe.rdEn;
  always_comb begin
    unique case (strobe.rdSrc)
      SRC_PC:   memAddr = pcQ;
      SRC_PC1:  memAddr = ADDR_W'(pcQ + ONE_ADDR);
      SRC_PTR:  memAddr = {ZERO_BYTE, ptrLo};
      SRC_PTR1: memAddr = {ZERO_BYTE, ptrHi};
      default:  memAddr = pcQ;
    endcase
  end

  // Index selection for indexed forms
  always_comb begin
    unique case (modeQ)
      MODE_ZPX, MODE_ABSX:            idx = xQ;
      MODE_ZPY, MODE_ABSY, MODE_INDY: idx = yQ;
      default:                        idx = ZERO_BYTE;
    endcase
  end

  assign zpSum    = BYTE_W'(opQ + idx);
  assign fullBase = {hiQ, loQ};

  always_comb begin
    unique case (modeQ)
      MODE_IMM:                         effAddr = pcQ;
      MODE_ZP, MODE_ZPX, MODE_ZPY:      effAddr = {ZERO_BYTE, zpSum};
      MODE_ABS, MODE_INDX:              effAddr = fullBase;
      MODE_ABSX, MODE_ABSY, MODE_INDY:  effAddr = ADDR_W'(fullBase + {ZERO_BYTE, idx});
      default:                          effAddr = '0;
    endcase
  end

  always_comb begin
    if (isAbsMode(modeQ))       opLen = LEN_W'(2);
    else if (modeQ > MODE_INDY) opLen = '0;
    else                        opLen = LEN_W'(1);
  end

endmodule

// File: rtl/oag_top.sv
module oag_top
  import oag_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        modeIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] xIn,
  input  logic [BYTE_W-1:0] yIn,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memData,
  output logic              busy,
  output logic              addrValid,
  output logic              modeErr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LEN_W-1:0]  opLen
);

  ctrlStrobe_t strobe;
  logic [3:0]  modeQ;

  oag_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeIn    (modeIn),
    .modeQ     (modeQ),
    .strobe    (strobe),
    .busy      (busy),
    .addrValid (addrValid),
    .modeErr   (modeErr)
  );

  oag_dpath #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .modeQ   (modeQ),
    .pcIn    (pcIn),
    .xIn     (xIn),
    .yIn     (yIn),
    .memData (memData),
    .memRd   (memRd),
    .memAddr (memAddr),
    .effAddr (effAddr),
    .opLen   (opLen)
  );

endmodule

// File: rtl/oag_checker.sv
module oag_checker #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [3:0]        modeIn,
  input logic [ADDR_W-1:0] pcIn,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              addrValid,
  input logic              modeErr,
  input logic [ADDR_W-1:0] effAddr,
  input logic [LEN_W-1:0]  opLen
);

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  a_r2_imm_result: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && modeIn == 4'd0 |=>
      addrValid && !memRd && effAddr == $past(pcIn) && opLen == LEN_W'(1));

  a_r3_first_read_at_pc: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && modeIn != 4'd0 && modeIn < 4'd9 |=>
      memRd && memAddr == $past(pcIn));

  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> opLen != '0);

  a_r9_reject: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && modeIn >= 4'd9 |=>
      modeErr && !addrValid && !memRd && opLen == '0);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && modeErr));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid && !busy);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> !modeErr && !busy);

  a_r10_read_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);

endmodule

bind oag_top oag_checker #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .modeIn    (modeIn),
  .pcIn      (pcIn),
  .memRd     (memRd),
  .memAddr   (memAddr),
  .busy      (busy),
  .addrValid (addrValid),
  .modeErr   (modeErr),
  .effAddr   (effAddr),
  .opLen     (opLen)
);

// File: tb/oag_top_tb_top.sv
`timescale 1ns/1ps
module oag_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  modeIn = '0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIn = '0, yIn = '0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        busy, addrValid, modeErr;
  logic [15:0] effAddr;
  logic [1:0]  opLen;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  byte unsigned ovr [int];

  always #4 clk = ~clk;

  oag_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .pcIn(pcIn),
    .xIn(xIn), .yIn(yIn), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busy(busy), .addrValid(addrValid), .modeErr(modeErr),
    .effAddr(effAddr), .opLen(opLen)
  );

  function automatic int memVal(int a);
    int aa = a & 16'hFFFF;
    if (ovr.exists(aa)) return ovr[aa];
    return ((aa & 8'hFF) ^ (((aa >> 8) * 29) & 8'hFF) ^ 8'h5A) & 8'hFF;
  endfunction

  // Synchronous memory: answers the cycle after a request
  always @(posedge clk) if (memRd) memData <= 8'(memVal(int'(memAddr)));

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // One request; called at a falling edge with the block idle
  task automatic runOp(int md, int pc, int x, int y, bit junk);
    int lat, expA, expL, op, ptr, lo, hi;
    int rd [int];
    string rq = reqOf(md);
    bit good = (md <= 8);
    op = memVal(pc);
    expL = 1;
    case (md)
      0: begin lat = 1; expA = pc; end
      1, 2, 3: begin
        lat = 3; rd[1] = pc;
        expA = (op + ((md == 2) ? x : (md == 3) ? y : 0)) & 8'hFF;
      end
      4, 5, 6: begin
        lat = 4; rd[1] = pc; rd[2] = (pc + 1) & 16'hFFFF; expL = 2;
        expA = (op | (memVal(pc + 1) << 8));
        expA = (expA + ((md == 5) ? x : (md == 6) ? y : 0)) & 16'hFFFF;
      end
      7, 8: begin
        lat = 6; rd[1] = pc;
        ptr = (md == 7) ? ((op + x) & 8'hFF) : op;
        rd[3] = ptr; rd[4] = (ptr + 1) & 8'hFF;
        lo = memVal(rd[3]); hi = memVal(rd[4]);
        expA = ((hi << 8) | lo);
        if (md == 8) expA = (expA + y) & 16'hFFFF;
      end
      default: begin lat = 1; expA = 0; expL = 0; end
    endcase
    check("R1", "busy idle", int'(busy), 0);
    start = 1'b1; modeIn = 4'(md); pcIn = 16'(pc); xIn = 8'(x); yIn = 8'(y);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      check(junk ? "R1" : rq, "busy", int'(busy), 1);
      check(good ? rq : "R9", "addrValid", int'(addrValid), int'(good && k == lat));
      check(good ? "R10" : "R9", "modeErr", int'(modeErr), int'(!good && k == lat));
      check(junk ? "R1" : rq, "memRd", int'(memRd), int'(rd.exists(k)));
      if (rd.exists(k)) check(rq, "memAddr", int'(memAddr), rd[k]);
      if (k == lat) begin
        if (good) check(rq, "effAddr", int'(effAddr), expA);
        check(rq, "opLen", int'(opLen), expL);
      end
      if (k == 1) begin
        if (junk && lat > 1) begin
          start = 1'b1; modeIn = 4'd0; pcIn = 16'h5555; xIn = 8'hAA; yIn = 8'h33;
        end else start = 1'b0;
      end
      if (k == lat) start = 1'b0;
    end
    @(negedge clk);
    check("R10", "busy after strobe", int'(busy), 0);
    check("R10", "no repeat valid", int'(addrValid), 0);
    check("R10", "no repeat err", int'(modeErr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset valid", int'(addrValid), 0);
    check("R9", "reset err", int'(modeErr), 0);
    check("R10", "reset memRd", int'(memRd), 0);
    rstN = 1'b1;
    @(negedge clk);
    ovr[16'h8000] = 8'h10;
    ovr[16'h8100] = 8'hF0;
    ovr[16'h8200] = 8'h80;
    ovr[16'h8010] = 8'h34; ovr[16'h8011] = 8'h12;
    ovr[16'h9000] = 8'hF0; ovr[16'h9001] = 8'hFF;
    ovr[16'h9100] = 8'hFF; ovr[16'h9101] = 8'h12;
    ovr[16'hA000] = 8'hFE;
    ovr[16'hA100] = 8'hFF;
    ovr[16'hA200] = 8'h40;
    ovr[8'hFF] = 8'hCD; ovr[8'h00] = 8'hAB;
    ovr[8'h40] = 8'hF0; ovr[8'h41] = 8'hFF;
    runOp(0, 16'h1234, 0, 0, 0);          // R2
    runOp(0, 16'hFFFF, 1, 2, 0);          // R2
    runOp(1, 16'h8000, 8'h77, 8'h66, 1);  // R3 with ignored start, R1
    runOp(2, 16'h8100, 8'h20, 0, 0);      // R4 page wrap -> 0x0010
    runOp(3, 16'h8200, 0, 8'h05, 1);      // R4
    runOp(4, 16'h8010, 0, 0, 0);          // R5 -> 0x1234
    runOp(4, 16'hFFFF, 0, 0, 0);          // R5 PC+1 wraps
    runOp(5, 16'h9000, 8'h20, 0, 1);      // R6 wrap -> 0x0010
    runOp(6, 16'h9100, 0, 8'h01, 0);      // R6 carry -> 0x1300
    runOp(7, 16'hA000, 8'h01, 0, 1);      // R7 pointer 0xFF, high at 0x00
    runOp(8, 16'hA100, 0, 8'h40, 0);      // R8 -> 0xAC0D
    runOp(8, 16'hA200, 0, 8'h20, 1);      // R8 16-bit wrap -> 0x0010
    runOp(9, 16'h1000, 0, 0, 0);          // R9
    runOp(15, 16'h2000, 0, 0, 0);         // R9
    for (int i = 0; i < 20; i++)
      runOp(i % 16, (i * 16'h1357) & 16'hFFFF, (i * 37) & 8'hFF, (i * 91) & 8'hFF, i[0]);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL R10 watchdog: actual 0x1 expected 0x0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule